// File: doc/BRIEF.md
# Shared Register Bus with Selectable Source

This block holds four equal-width storage registers that exchange data over one common bus. A select code picks which register drives the bus. Each register has its own load strobe and takes the bus value on the rising clock edge when that strobe is high.

Only one value can be on the bus in a cycle, but any number of registers may capture it on the same edge. A bus-enable input models a three-state bus. When it is low, no register drives the bus and the bus reads as all zeros. An external data port can take over the bus, so that values can be brought into the register set.

A build parameter picks how the bus is formed. One variant uses a per-bit 4-to-1 multiplexer under the select. The other decodes the select into a one-hot driver enable and combines the sources by AND-OR, as in the three-state form. The two variants behave the same at the ports.

Top module: `sharedRegBus`

## Requirements
- R1: While the active-low reset is asserted, all four registers clear to zero.
- R2: With the external drive low and the bus enable high, the select picks the source on the bus. Code 0 drives register A, 1 drives B, 2 drives C and 3 drives D. The bus output shows that register's value in the same cycle.
- R3: With both the external drive and the bus enable low, the bus output is all zeros, whatever the select.
- R4: With the external drive high, the bus output equals the external data. The select and the bus enable have no effect on it.
- R5: A register whose load bit is 1 takes the bus value at the clock edge. A register whose load bit is 0 keeps its value.
- R6: When several load bits are high on one edge, every selected register takes the same bus value.
- R7: A register that is both the bus source and a destination in one cycle keeps its own value.
- R8: A load while the bus is disabled writes zero into the destination.
- R9: Register k (A=0, B=1, C=2, D=3) sits in bits [k*WIDTH +: WIDTH] of the register output, and load bit k belongs to register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| srcSel | input | 2 | Bus source select |
| busEn | input | 1 | Register driver enable; when low, the bus reads zero |
| extDrive | input | 1 | External data takes over the bus |
| extData | input | WIDTH | External bus value |
| loadEn | input | 4 | Per-register load strobes |
| busOut | output | WIDTH | Current bus value |
| regsOut | output | 4*WIDTH | All register contents, packed |

## Verification
A register can drive the bus and load from it in the same cycle. Several registers can also capture one bus value on the same edge. The bench sets the select and the load mask together so that both cases happen. In one step, register A feeds C and D. In another, register D is both source and destination. The expected register set for every step comes from a reference model in the bench and is compared after the edge. The comparison confirms that every targeted register took the bus value, that the source kept its own value, and that all other registers held.

// File: rtl/sharedRegBusPkg.sv
package sharedRegBusPkg;
  parameter int unsigned RegCount = 4;
  localparam int unsigned SelW = $clog2(RegCount);

  typedef struct packed {
    logic [SelW-1:0]     sel;
    logic [RegCount-1:0] drive;
    logic                extDrive;
    logic [RegCount-1:0] load;
  } strobeT;
endpackage

// File: rtl/sharedRegBusCtrl.sv
module sharedRegBusCtrl
  import sharedRegBusPkg::*;
(
  input  logic [SelW-1:0]     srcSel,
  input  logic                busEn,
  input  logic                extDrive,
  input  logic [RegCount-1:0] loadEn,
  output strobeT              strobes
);
  logic [RegCount-1:0] decoded;

  always_comb begin
    decoded = '0;
    for (int k = 0; k < RegCount; k++) begin
      if (srcSel == SelW'(k)) decoded[k] = 1'b1;
    end
  end

  always_comb begin
    strobes.sel      = srcSel;
    strobes.drive    = (busEn && !extDrive) ? decoded : '0;
    strobes.extDrive = extDrive;
    strobes.load     = loadEn;
  end
endmodule

// File: rtl/sharedRegBusPath.sv
module sharedRegBusPath
  import sharedRegBusPkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter bit          USE_ONEHOT = 1'b0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobeT                    strobes,
  input  logic [WIDTH-1:0]          extData,
  output logic [WIDTH-1:0]          busOut,
  output logic [RegCount*WIDTH-1:0] regsOut
);
  logic [WIDTH-1:0] regQ [RegCount];
  logic [WIDTH-1:0] regBus;

  generate
    if (USE_ONEHOT) begin : g_andOr
      always_comb begin
        regBus = '0;
        for (int k = 0; k < RegCount; k++) begin
          regBus = regBus | (regQ[k] & {WIDTH{strobes.drive[k]}});
        end
      end
    end else begin : g_mux
      always_comb begin
        regBus = strobes.drive[strobes.sel] ? regQ[strobes.sel] : '0;
      end
    end
  endgenerate

  assign busOut = strobes.extDrive ? extData : regBus;

  for (genvar k = 0; k < RegCount; k++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[k] <= '0;
      end else if (strobes.load[k]) begin
        regQ[k] <= busOut;
      end
    end
    assign regsOut[k*WIDTH +: WIDTH] = regQ[k];
  end
endmodule

// File: rtl/sharedRegBus.sv
module sharedRegBus
  import sharedRegBusPkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter bit          USE_ONEHOT = 1'b0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [SelW-1:0]           srcSel,
  input  logic                      busEn,
  input  logic                      extDrive,
  input  logic [WIDTH-1:0]          extData,
  input  logic [RegCount-1:0]       loadEn,
  output logic [WIDTH-1:0]          busOut,
  output logic [RegCount*WIDTH-1:0] regsOut
);
  strobeT strobes;

  sharedRegBusCtrl u_ctrl (
    .srcSel   (srcSel),
    .busEn    (busEn),
    .extDrive (extDrive),
    .loadEn   (loadEn),
    .strobes  (strobes)
  );

  sharedRegBusPath #(.WIDTH(WIDTH), .USE_ONEHOT(USE_ONEHOT)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .extData (extData),
    .busOut  (busOut),
    .regsOut (regsOut)
  );
endmodule

// File: rtl/sharedRegBusChecker.sv
module sharedRegBusChecker
  import sharedRegBusPkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [SelW-1:0]           srcSel,
  input logic                      busEn,
  input logic                      extDrive,
  input logic [WIDTH-1:0]          extData,
  input logic [RegCount-1:0]       loadEn,
  input logic [WIDTH-1:0]          busOut,
  input logic [RegCount*WIDTH-1:0] regsOut
);
  assert_bus_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !extDrive) |-> busOut == regsOut[srcSel*WIDTH +: WIDTH]);

  assert_bus_idle_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busEn && !extDrive) |-> busOut == '0);

  assert_ext_override_R4: assert property (@(posedge clk) disable iff (!rstN)
    extDrive |-> busOut == extData);

  for (genvar k = 0; k < RegCount; k++) begin : g_chk
    // R5 and R9: load bit k captures the bus into slice k
    assert_load_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
      loadEn[k] |=> regsOut[k*WIDTH +: WIDTH] == $past(busOut));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      !loadEn[k] |=> $stable(regsOut[k*WIDTH +: WIDTH]));
  end
endmodule

bind sharedRegBus sharedRegBusChecker #(.WIDTH(WIDTH)) u_checker (.*);

// File: tb/test_sharedRegBus.sv
module test_sharedRegBus;
  localparam int W = 8;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [1:0]     srcSel = '0;
  logic           busEn = 1'b0;
  logic           extDrive = 1'b0;
  logic [W-1:0]   extData = '0;
  logic [N-1:0]   loadEn = '0;
  logic [W-1:0]   busOut;
  logic [N*W-1:0] regsOut;

  sharedRegBus #(.WIDTH(W)) i_sharedRegBus (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [W-1:0]   bus;
    logic [N*W-1:0] regs;
    string          tag;
  } itemT;

  itemT         sbq[$];
  logic [W-1:0] model [N];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] packModel();
    logic [N*W-1:0] p;
    for (int k = 0; k < N; k++) p[k*W +: W] = model[k];
    return p;
  endfunction

  task automatic step(input logic [1:0] sel, input logic en, input logic ext,
                      input logic [W-1:0] data, input logic [N-1:0] ld, input string tag);
    itemT it;
    @(negedge clk);
    srcSel = sel; busEn = en; extDrive = ext; extData = data; loadEn = ld;
    it.bus = ext ? data : (en ? model[sel] : '0);
    for (int k = 0; k < N; k++) if (ld[k]) model[k] = it.bus;
    it.regs = packModel();
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor
  initial begin
    itemT it;
    forever begin
      @(negedge clk);
      #5;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check(busOut === it.bus, {it.tag, " bus"}, {{(N-1)*W{1'b0}}, busOut}, {{(N-1)*W{1'b0}}, it.bus});
        @(posedge clk);
        #5;
        check(regsOut === it.regs, {it.tag, " regs"}, regsOut, it.regs);
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) model[k] = '0;
    // R1: registers clear under reset, even with loads requested
    loadEn = '1; extDrive = 1'b1; extData = 8'hFF;
    repeat (2) @(posedge clk);
    #5;
    check(regsOut === '0, "R1 reset clear", regsOut, '0);
    @(negedge clk);
    loadEn = '0; extDrive = 1'b0;
    rstN = 1'b1;
    // R4, R5, R9: fill each register through the external path
    step(2'd3, 1'b0, 1'b1, 8'h11, 4'b0001, "R4 R5 R9 load A");
    step(2'd0, 1'b1, 1'b1, 8'h22, 4'b0010, "R4 R5 R9 load B");
    step(2'd1, 1'b0, 1'b1, 8'h33, 4'b0100, "R4 R5 R9 load C");
    step(2'd2, 1'b1, 1'b1, 8'h44, 4'b1000, "R4 R5 R9 load D");
    // R2: each select code drives its register
    step(2'd0, 1'b1, 1'b0, 8'hEE, 4'b0000, "R2 select A");
    step(2'd1, 1'b1, 1'b0, 8'hEE, 4'b0000, "R2 select B");
    step(2'd2, 1'b1, 1'b0, 8'hEE, 4'b0000, "R2 select C");
    step(2'd3, 1'b1, 1'b0, 8'hEE, 4'b0000, "R2 select D");
    // R3: disabled bus reads zero
    step(2'd2, 1'b0, 1'b0, 8'hEE, 4'b0000, "R3 idle bus");
    // R6: A to C and D on one edge
    step(2'd0, 1'b1, 1'b0, 8'h00, 4'b1100, "R6 multi dest");
    // R7: D is source and destination
    step(2'd3, 1'b1, 1'b0, 8'h00, 4'b1000, "R7 self load");
    // R5: B to A, others hold
    step(2'd1, 1'b1, 1'b0, 8'h00, 4'b0001, "R5 copy B to A");
    // R8: load while disabled writes zero
    step(2'd1, 1'b0, 1'b0, 8'h5A, 4'b0010, "R8 disabled load");
    // R4: external overrides enabled select
    step(2'd0, 1'b1, 1'b1, 8'hA5, 4'b0110, "R4 override");
    step(2'd2, 1'b1, 1'b0, 8'h00, 4'b0000, "R2 readback C");
    step(2'd0, 1'b0, 1'b0, 8'h00, 4'b0000, "R3 final idle");
    wait (sbq.size() == 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule